// File: doc/BRIEF.md
# Two-Port Memory Collision Arbiter

This block sits beside a memory with two independent access ports, called left and right. On every clock it samples each port's select, address and write request. It decides which port may go ahead when both ports are selected on the same word. The losing port sees an active-low busy flag and must hold its operation. The same flag suppresses that port's write enable, so the memory never sees the losing write.

The winner depends on the order of events. If both addresses already match and the selects arrive at different times, the port that was selected first wins. If both ports are already selected and one address moves onto the other, the port that was already sitting on that address wins. Both rules reduce to one idea. A port whose select or address changed in the current cycle is "fresh", and a port that is not fresh beats one that is. When both ports are equally fresh, the left port wins.

The owner holds the word until it deselects or moves away. The loser's busy flag then clears in that same cycle, and the loser proceeds. Several of these blocks can be placed side by side to build a wider memory. In that case one block is strapped as master and the others as slaves. A slave does no arbitration of its own. It keeps its own busy outputs inactive and gates its writes with the master's busy flags, which it receives as inputs. A slave write is held off until the master's flag for that port has been inactive for two consecutive samples.

Top module: `dpc_arbiter`

## Requirements
- R1: Busy flags are asserted only when both ports are selected and their addresses are equal. Out of reset, and whenever there is no collision, both busy outputs are 1.
- R2: When the addresses already match and one port becomes selected while the other is already selected, the previously selected port wins. The loser's busy output goes to 0 in that same cycle.
- R3: When both ports are already selected and one port's address changes to equal the other's, the port whose address did not change wins.
- R4: When both ports become fresh on the same word in the same cycle, the left port wins. Here, fresh means newly selected, or selected with a changed address.
- R5: At most one busy output is 0 at a time. The loser stays busy for as long as the owner stays selected on the same address.
- R6: When the owner deselects, or the two addresses stop being equal, the loser's busy output returns to 1 in that same cycle, and its write is passed through.
- R7: With `is_master` = 0 (slave), both busy outputs are held at 1, whatever the inputs.
- R8: In master mode, `we_x` = `wr_x` AND `sel_x` AND `busy_x_n`. A busy or deselected port produces no write enable.
- R9: In slave mode, `we_x` = `wr_x` AND `sel_x` AND `busy_in_x_n`, and it also requires that `busy_in_x_n` was 1 at the previous clock edge. After reset, the previous sample counts as 0.
- R10: In master mode the busy inputs from a master have no effect on the write enables.

FSM states: `ST_IDLE` (no owner), `ST_LEFT_OWNS`, `ST_RIGHT_OWNS`.

Transitions:
- IDLE to an owner state: on a collision, with the owner chosen by the freshness rule.
- Owner state to itself: while the collision persists and the owner is not fresh.
- Owner state re-arbitrates: if the owner became fresh while a collision remains.
- Owner state to IDLE: when the collision ends.
- Any state to IDLE: when the block is in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master (arbitrates), 0 = slave |
| sel_l | input | 1 | Left port select, active high |
| addr_l | input | AW | Left port word address |
| wr_l | input | 1 | Left port write request |
| sel_r | input | 1 | Right port select, active high |
| addr_r | input | AW | Right port word address |
| wr_r | input | 1 | Right port write request |
| busy_in_l_n | input | 1 | Master's left busy flag (used in slave mode) |
| busy_in_r_n | input | 1 | Master's right busy flag (used in slave mode) |
| busy_l_n | output | 1 | Left busy flag, active low |
| busy_r_n | output | 1 | Right busy flag, active low |
| we_l | output | 1 | Gated left write enable |
| we_r | output | 1 | Gated right write enable |

## Verification
The assertions check, on every cycle, the invariants that need no history of who arrived first. These are: never two busy flags at once, busy only during a real collision, inactive flags in slave mode, no write past an active busy flag, and the two-sample settle rule for slave writes. Which port wins depends on the order in which selects and addresses arrived. The same goes for holding the loser while the owner stays, and for handing over when the owner leaves. Only the bench's ordered scenarios can show these behaviours, because each one compares the outputs against a hand-derived winner.

// File: rtl/dpc_arb_pkg.sv
package dpc_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LEFT_OWNS  = 2'd1,
        ST_RIGHT_OWNS = 2'd2
    } own_state_t;
endpackage

// File: rtl/dpc_port_tracker.sv
// Remembers last cycle's select/address of one port and flags a port
// whose access began (or moved) in the current cycle.
module dpc_port_tracker #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    output logic          fresh
);
    logic          sel_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            sel_q  <= sel;
            addr_q <= addr;
        end
    end

    always_comb begin
        fresh = sel && (!sel_q || (addr != addr_q));
    end
endmodule

// File: rtl/dpc_grant_fsm.sv
// Ownership state machine; exposes the grant in force this cycle.
module dpc_grant_fsm
    import dpc_arb_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          sel_l,
    input  logic          sel_r,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    input  logic          fresh_l,
    input  logic          fresh_r,
    output own_state_t    grant
);
    own_state_t state_q;
    own_state_t state_d;
    logic       clash;
    own_state_t pick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        clash = sel_l && sel_r && (addr_l == addr_r);
        // The settled port beats the one that just arrived; ties go left.
        pick  = (fresh_l && !fresh_r) ? ST_RIGHT_OWNS : ST_LEFT_OWNS;
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                state_d = clash ? pick : ST_IDLE;
            end
            ST_LEFT_OWNS: begin
                if (clash && !fresh_l) state_d = ST_LEFT_OWNS;
                else if (clash)        state_d = pick;
                else                   state_d = ST_IDLE;
            end
            ST_RIGHT_OWNS: begin
                if (clash && !fresh_r) state_d = ST_RIGHT_OWNS;
                else if (clash)        state_d = pick;
                else                   state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        if (!enable) state_d = ST_IDLE;
    end

    assign grant = state_d;
endmodule

// File: rtl/dpc_write_gate.sv
// Per-port write qualifier: own busy flag as master, settled external
// busy flag as slave.
module dpc_write_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic is_master,
    input  logic sel,
    input  logic wr,
    input  logic own_busy_n,
    input  logic ext_busy_n,
    output logic we
);
    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_busy_n;
    end

    always_comb begin
        if (is_master) we = sel && wr && own_busy_n;
        else           we = sel && wr && ext_busy_n && ext_q;
    end
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
    import dpc_arb_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_master,
    input  logic          sel_l,
    input  logic [AW-1:0] addr_l,
    input  logic          wr_l,
    input  logic          sel_r,
    input  logic [AW-1:0] addr_r,
    input  logic          wr_r,
    input  logic          busy_in_l_n,
    input  logic          busy_in_r_n,
    output logic          busy_l_n,
    output logic          busy_r_n,
    output logic          we_l,
    output logic          we_r
);
    logic       fresh_l;
    logic       fresh_r;
    own_state_t grant;

    dpc_port_tracker #(.AW(AW)) trk_l_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_l), .addr(addr_l), .fresh(fresh_l)
    );
    dpc_port_tracker #(.AW(AW)) trk_r_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_r), .addr(addr_r), .fresh(fresh_r)
    );

    dpc_grant_fsm #(.AW(AW)) fsm_i (
        .clk(clk), .rst_n(rst_n), .enable(is_master),
        .sel_l(sel_l), .sel_r(sel_r), .addr_l(addr_l), .addr_r(addr_r),
        .fresh_l(fresh_l), .fresh_r(fresh_r), .grant(grant)
    );

    // Output decode from the grant in force this cycle.
    always_comb begin
        busy_l_n = 1'b1;
        busy_r_n = 1'b1;
        unique case (grant)
            ST_LEFT_OWNS:  busy_r_n = 1'b0;
            ST_RIGHT_OWNS: busy_l_n = 1'b0;
            default: ;
        endcase
    end

    dpc_write_gate gate_l_i (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .sel(sel_l),
        .wr(wr_l), .own_busy_n(busy_l_n), .ext_busy_n(busy_in_l_n), .we(we_l)
    );
    dpc_write_gate gate_r_i (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .sel(sel_r),
        .wr(wr_r), .own_busy_n(busy_r_n), .ext_busy_n(busy_in_r_n), .we(we_r)
    );
endmodule

// File: rtl/dpc_arbiter_chk.sv
module dpc_arbiter_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          is_master,
    input logic          sel_l,
    input logic [AW-1:0] addr_l,
    input logic          wr_l,
    input logic          sel_r,
    input logic [AW-1:0] addr_r,
    input logic          wr_r,
    input logic          busy_in_l_n,
    input logic          busy_in_r_n,
    input logic          busy_l_n,
    input logic          busy_r_n,
    input logic          we_l,
    input logic          we_r
);
    p_single_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_l_n && !busy_r_n));

    p_busy_needs_clash_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_l_n || !busy_r_n) |-> (sel_l && sel_r && addr_l == addr_r));

    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (busy_l_n && busy_r_n));

    p_master_gate_l_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_l |-> (sel_l && wr_l && (!is_master || busy_l_n)));

    p_master_gate_r_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_r |-> (sel_r && wr_r && (!is_master || busy_r_n)));

    p_slave_settle_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && we_l) |-> (busy_in_l_n && $past(busy_in_l_n)));

    p_slave_settle_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && we_r) |-> (busy_in_r_n && $past(busy_in_r_n)));
endmodule

bind dpc_arbiter dpc_arbiter_chk #(.AW(AW)) chk_i (.*);

// File: tb/dpc_arbiter_tb_top.sv
module dpc_arbiter_tb_top;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_master = 1'b1;
    logic          sel_l = 1'b0, wr_l = 1'b0, sel_r = 1'b0, wr_r = 1'b0;
    logic [AW-1:0] addr_l = '0, addr_r = '0;
    logic          busy_in_l_n = 1'b1, busy_in_r_n = 1'b1;
    logic          busy_l_n, busy_r_n, we_l, we_r;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic  bl, br, wl, wr;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    dpc_arbiter #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .sel_l(sel_l), .addr_l(addr_l), .wr_l(wr_l),
        .sel_r(sel_r), .addr_r(addr_r), .wr_r(wr_r),
        .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
        .busy_l_n(busy_l_n), .busy_r_n(busy_r_n), .we_l(we_l), .we_r(we_r)
    );

    task automatic step(input logic m,
                        input logic sl, input logic [AW-1:0] al, input logic wl,
                        input logic sr, input logic [AW-1:0] ar, input logic wrr,
                        input logic bil, input logic bir,
                        input logic ebl, input logic ebr,
                        input logic ewl, input logic ewr,
                        input string tag);
        exp_t e;
        @(negedge clk);
        is_master = m;
        sel_l = sl; addr_l = al; wr_l = wl;
        sel_r = sr; addr_r = ar; wr_r = wrr;
        busy_in_l_n = bil; busy_in_r_n = bir;
        e.bl = ebl; e.br = ebr; e.wl = ewl; e.wr = ewr; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare once outputs have settled after each drive.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ({busy_l_n, busy_r_n, we_l, we_r} !== {e.bl, e.br, e.wl, e.wr}) begin
                    failures++;
                    $display("FAIL %s: got bl=%b br=%b wl=%b wr=%b exp bl=%b br=%b wl=%b wr=%b",
                             e.tag, busy_l_n, busy_r_n, we_l, we_r, e.bl, e.br, e.wl, e.wr);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (!(busy_l_n && busy_r_n && !we_l && !we_r)) begin
            failures++;
            $display("FAIL R1 in reset: got bl=%b br=%b exp 1 1", busy_l_n, busy_r_n);
        end
        @(negedge clk);
        rst_n = 1'b1;
        //     m  sl al wl  sr ar wr  bil bir  ebl ebr ewl ewr
        step(1, 0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R1 idle after reset");
        step(1, 1, 2, 1,  1, 6, 1,  1, 1,  1, 1, 1, 1, "R1 distinct addresses");
        step(1, 0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R1 deselected");
        step(1, 1, 5, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R2 left selects first");
        step(1, 1, 5, 1,  1, 5, 1,  1, 1,  1, 0, 1, 0, "R2 earlier select wins, R8 loser write blocked");
        step(1, 1, 5, 1,  1, 5, 1,  1, 1,  1, 0, 1, 0, "R5 loser held while owner stays");
        step(1, 0, 5, 0,  1, 5, 1,  1, 1,  1, 1, 0, 1, "R6 owner deselects, loser proceeds");
        step(1, 1, 5, 1,  1, 5, 1,  1, 1,  0, 1, 0, 1, "R2 right selected earlier wins");
        step(1, 0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R1 deselected");
        step(1, 1, 3, 0,  1, 7, 0,  1, 1,  1, 1, 0, 0, "R3 setup distinct addresses");
        step(1, 1, 7, 1,  1, 7, 1,  1, 1,  0, 1, 0, 1, "R3 left moved onto right, right wins");
        step(1, 1, 7, 1,  1, 9, 1,  1, 1,  1, 1, 1, 1, "R6 owner moves away, release");
        step(1, 1, 7, 1,  1, 7, 1,  1, 1,  1, 0, 1, 0, "R3 right moved onto left, left wins");
        step(1, 0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R1 deselected");
        step(1, 1, 4, 1,  1, 4, 1,  1, 1,  1, 0, 1, 0, "R4 simultaneous arrival, left wins");
        step(1, 0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R1 deselected");
        step(0, 1, 4, 1,  1, 4, 1,  0, 1,  1, 1, 0, 1, "R7 slave quiet, R9 master busy blocks");
        step(0, 1, 4, 1,  1, 4, 1,  1, 1,  1, 1, 0, 1, "R9 first clear sample still blocked");
        step(0, 1, 4, 1,  1, 4, 1,  1, 1,  1, 1, 1, 1, "R9 settled clear allows write");
        step(0, 0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R7 slave deselected");
        step(1, 0, 0, 0,  0, 0, 0,  1, 1,  1, 1, 0, 0, "R1 back to master");
        step(1, 1, 1, 1,  1, 8, 1,  0, 0,  1, 1, 1, 1, "R10 busy inputs ignored in master");
        step(1, 0, 1, 1,  1, 8, 1,  0, 0,  1, 1, 0, 1, "R8 write without select dropped");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule